// File: doc/BRIEF.md
# Dual-Rail Trust-Tracking Gate Library

This block is a combinational library of logic gates that carry a trust label next to every value. Each logical signal travels as a two-bit code. Trusted values appear as 00 or 11, and any untrusted value appears as the single symbol 01, whatever its underlying value. The gates are a two-input AND, OR and XOR and an inverter. Each gate marks its output untrusted only when an untrusted input could really change the result. The tracking logic uses only the coded inputs and never taps any net of the plain, untracked circuit.

As a worked composition, the library builds a 2:1 multiplexer out of its own gates. A plain copy of the same multiplexer sits beside it. When every coded input is trusted, the high rail and the low rail of the coded result each repeat the plain result. The plain result and the two rails therefore form three copies. A per-lane majority voter reduces them to one bit and flags a disagreement while all inputs are trusted. Every port is a vector of `LANES` independent lanes.

Top module: `trust_gate_lib`

## Requirements
- R1: Lane i of every coded port sits at bits [2i+1:2i], with the high rail at bit 2i+1. Code 00 is trusted 0, 11 is trusted 1 and 01 is untrusted. No coded output ever carries 10.
- R2: Any gate input carrying the unused code 10 is handled exactly as the untrusted code 01.
- R3: AND gives 00 when either input is 00, gives 11 when both inputs are 11, and gives 01 in every other case.
- R4: OR gives 11 when either input is 11, gives 00 when both inputs are 00, and gives 01 in every other case.
- R5: XOR gives 01 when either input is untrusted. With two trusted inputs it gives the trusted XOR of their values (11 when they differ, 00 when they are equal).
- R6: The inverter maps 00 to 11 and 11 to 00, and gives 01 for an untrusted input.
- R7: The coded multiplexer computes (d0 AND NOT sel) OR (d1 AND sel) from library gates. With sel at 00 it outputs d0's code, and with sel at 11 it outputs d1's code, with 10 read as 01 in both cases. With an untrusted sel it gives 00 if both data inputs are 00, and 01 otherwise.
- R8: vote_y[i] is the majority of three bits: the plain multiplexer result (plain_sel[i] ? plain_d1[i] : plain_d0[i]) and the two rails of coded lane i of mux_y.
- R9: vote_err[i] is 1 exactly when coded sel, d0 and d1 of lane i are all trusted and the three copies of R8 are not all equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| and_a | input | 2*LANES | AND operand A, coded |
| and_b | input | 2*LANES | AND operand B, coded |
| and_y | output | 2*LANES | AND result, coded |
| or_a | input | 2*LANES | OR operand A, coded |
| or_b | input | 2*LANES | OR operand B, coded |
| or_y | output | 2*LANES | OR result, coded |
| xor_a | input | 2*LANES | XOR operand A, coded |
| xor_b | input | 2*LANES | XOR operand B, coded |
| xor_y | output | 2*LANES | XOR result, coded |
| inv_a | input | 2*LANES | Inverter operand, coded |
| inv_y | output | 2*LANES | Inverter result, coded |
| mux_sel | input | 2*LANES | Coded multiplexer select |
| mux_d0 | input | 2*LANES | Coded data picked when the select is 0 |
| mux_d1 | input | 2*LANES | Coded data picked when the select is 1 |
| mux_y | output | 2*LANES | Coded multiplexer result |
| plain_sel | input | LANES | Select of the plain multiplexer |
| plain_d0 | input | LANES | Plain data picked when the select is 0 |
| plain_d1 | input | LANES | Plain data picked when the select is 1 |
| vote_y | output | LANES | Majority of the plain result and both coded rails |
| vote_err | output | LANES | Disagreement among the three copies while all coded inputs are trusted |

## Verification
The assertions run at every input change. They check the dominance rules of AND and OR, the forcing of XOR to untrusted, the treatment of code 10, the inverter on trusted values, the absence of code 10 at every output, and that the voter's flag never rises while any coded input is untrusted. The full truth tables, the composed multiplexer's behaviour under an untrusted select, and the majority voter under injected disagreement between the plain and coded copies are shown only by the bench. The bench walks every combination of the four input codes on every lane.

// File: rtl/trust_pkg.sv
package trust_pkg;

   typedef logic [1:0] tcode_t;

   localparam tcode_t TC_ZERO = 2'b00;
   localparam tcode_t TC_ONE  = 2'b11;
   localparam tcode_t TC_UNK  = 2'b01;
   localparam tcode_t TC_BAD  = 2'b10;

   typedef enum logic [1:0] {
      GOP_AND = 2'd0,
      GOP_OR  = 2'd1,
      GOP_XOR = 2'd2
   } gate_op_e;

   // Fold the unused code onto the untrusted symbol.
   function automatic tcode_t tc_clean(tcode_t c);
      return (c == TC_BAD) ? TC_UNK : c;
   endfunction

   // A code is trusted when both rails agree.
   function automatic logic tc_known(tcode_t c);
      return c[1] == c[0];
   endfunction

endpackage

// File: rtl/trust_gate2.sv
module trust_gate2
   import trust_pkg::*;
#(
   parameter int       LANES = 4,
   parameter gate_op_e OP    = GOP_AND
) (
   input  logic [2*LANES-1:0] a,
   input  logic [2*LANES-1:0] b,
   output logic [2*LANES-1:0] y
);
   if (LANES < 1) begin : g_bad_lanes
      $error("trust_gate2: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      tcode_t ca, cb, cy;
      assign ca = tc_clean(a[2*i +: 2]);
      assign cb = tc_clean(b[2*i +: 2]);

      if (OP == GOP_AND) begin : g_and
         // rail-wise: 00 dominates, 01 survives only against 11
         assign cy = {ca[1] & cb[1], ca[0] & cb[0]};
      end else if (OP == GOP_OR) begin : g_or
         assign cy = {ca[1] | cb[1], ca[0] | cb[0]};
      end else begin : g_xor
         logic unk;
         logic val;
         assign unk = ~tc_known(ca) | ~tc_known(cb);
         assign val = ca[1] ^ cb[1];
         assign cy  = unk ? TC_UNK : {val, val};
      end

      assign y[2*i +: 2] = cy;
   end
endmodule

// File: rtl/trust_inv.sv
module trust_inv
   import trust_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [2*LANES-1:0] a,
   output logic [2*LANES-1:0] y
);
   if (LANES < 1) begin : g_bad_lanes
      $error("trust_inv: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      tcode_t ca;
      assign ca = tc_clean(a[2*i +: 2]);
      // swap and invert rails: 00<->11, 01 stays 01
      assign y[2*i +: 2] = {~ca[0], ~ca[1]};
   end
endmodule

// File: rtl/trust_mux.sv
module trust_mux
   import trust_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [2*LANES-1:0] sel,
   input  logic [2*LANES-1:0] d0,
   input  logic [2*LANES-1:0] d1,
   output logic [2*LANES-1:0] y
);
   logic [2*LANES-1:0] sel_n;
   logic [2*LANES-1:0] pick0;
   logic [2*LANES-1:0] pick1;

   trust_inv #(.LANES(LANES)) u_inv (
      .a (sel),
      .y (sel_n)
   );

   trust_gate2 #(.LANES(LANES), .OP(GOP_AND)) u_and0 (
      .a (d0),
      .b (sel_n),
      .y (pick0)
   );

   trust_gate2 #(.LANES(LANES), .OP(GOP_AND)) u_and1 (
      .a (d1),
      .b (sel),
      .y (pick1)
   );

   trust_gate2 #(.LANES(LANES), .OP(GOP_OR)) u_or (
      .a (pick0),
      .b (pick1),
      .y (y)
   );
endmodule

// File: rtl/trust_voter.sv
module trust_voter #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0]   plain,
   input  logic [2*LANES-1:0] coded,
   input  logic [LANES-1:0]   all_trusted,
   output logic [LANES-1:0]   vote,
   output logic [LANES-1:0]   err
);
   if (LANES < 1) begin : g_bad_lanes
      $error("trust_voter: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic p, h, l, same;
      assign p    = plain[i];
      assign h    = coded[2*i+1];
      assign l    = coded[2*i];
      assign vote[i] = (p & h) | (p & l) | (h & l);
      assign same = (p == h) && (h == l);
      assign err[i]  = all_trusted[i] & ~same;
   end
endmodule

// File: rtl/trust_gate_lib.sv
module trust_gate_lib
   import trust_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [2*LANES-1:0] and_a,
   input  logic [2*LANES-1:0] and_b,
   output logic [2*LANES-1:0] and_y,
   input  logic [2*LANES-1:0] or_a,
   input  logic [2*LANES-1:0] or_b,
   output logic [2*LANES-1:0] or_y,
   input  logic [2*LANES-1:0] xor_a,
   input  logic [2*LANES-1:0] xor_b,
   output logic [2*LANES-1:0] xor_y,
   input  logic [2*LANES-1:0] inv_a,
   output logic [2*LANES-1:0] inv_y,
   input  logic [2*LANES-1:0] mux_sel,
   input  logic [2*LANES-1:0] mux_d0,
   input  logic [2*LANES-1:0] mux_d1,
   output logic [2*LANES-1:0] mux_y,
   input  logic [LANES-1:0]   plain_sel,
   input  logic [LANES-1:0]   plain_d0,
   input  logic [LANES-1:0]   plain_d1,
   output logic [LANES-1:0]   vote_y,
   output logic [LANES-1:0]   vote_err
);
   localparam int CW = 2 * LANES;

   if (LANES < 1 || LANES > 256) begin : g_bad_lanes
      $error("trust_gate_lib: LANES out of range");
   end

   trust_gate2 #(.LANES(LANES), .OP(GOP_AND)) u_and (
      .a (and_a), .b (and_b), .y (and_y)
   );

   trust_gate2 #(.LANES(LANES), .OP(GOP_OR)) u_or (
      .a (or_a), .b (or_b), .y (or_y)
   );

   trust_gate2 #(.LANES(LANES), .OP(GOP_XOR)) u_xor (
      .a (xor_a), .b (xor_b), .y (xor_y)
   );

   trust_inv #(.LANES(LANES)) u_inv (
      .a (inv_a), .y (inv_y)
   );

   // coded copy of the multiplexer, built only from coded inputs
   logic [CW-1:0] mux_coded;
   trust_mux #(.LANES(LANES)) u_mux (
      .sel (mux_sel), .d0 (mux_d0), .d1 (mux_d1), .y (mux_coded)
   );
   assign mux_y = mux_coded;

   // plain copy and trust summary per lane
   logic [LANES-1:0] plain_y;
   logic [LANES-1:0] lane_trusted;
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign plain_y[i] = plain_sel[i] ? plain_d1[i] : plain_d0[i];
      assign lane_trusted[i] = tc_known(mux_sel[2*i +: 2]) &
                               tc_known(mux_d0[2*i +: 2]) &
                               tc_known(mux_d1[2*i +: 2]);
   end

   trust_voter #(.LANES(LANES)) u_vote (
      .plain       (plain_y),
      .coded       (mux_coded),
      .all_trusted (lane_trusted),
      .vote        (vote_y),
      .err         (vote_err)
   );
endmodule

// File: rtl/trust_gate_lib_chk.sv
module trust_gate_lib_chk #(
   parameter int LANES = 4
) (
   input logic [2*LANES-1:0] and_a,
   input logic [2*LANES-1:0] and_b,
   input logic [2*LANES-1:0] and_y,
   input logic [2*LANES-1:0] or_a,
   input logic [2*LANES-1:0] or_b,
   input logic [2*LANES-1:0] or_y,
   input logic [2*LANES-1:0] xor_a,
   input logic [2*LANES-1:0] xor_b,
   input logic [2*LANES-1:0] xor_y,
   input logic [2*LANES-1:0] inv_a,
   input logic [2*LANES-1:0] inv_y,
   input logic [2*LANES-1:0] mux_sel,
   input logic [2*LANES-1:0] mux_d0,
   input logic [2*LANES-1:0] mux_d1,
   input logic [2*LANES-1:0] mux_y,
   input logic [LANES-1:0]   vote_err
);
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         a_r1_no_bad_code: assert (and_y[2*i +: 2] != 2'b10 && or_y[2*i +: 2] != 2'b10 &&
                                   xor_y[2*i +: 2] != 2'b10 && inv_y[2*i +: 2] != 2'b10 &&
                                   mux_y[2*i +: 2] != 2'b10)
            else $error("R1: output code 10 on lane %0d", i);

         if (and_a[2*i +: 2] == 2'b00 || and_b[2*i +: 2] == 2'b00) begin
            a_r3_and_zero_wins: assert (and_y[2*i +: 2] == 2'b00)
               else $error("R3: AND lane %0d not trusted 0", i);
         end

         if (or_a[2*i +: 2] == 2'b11 || or_b[2*i +: 2] == 2'b11) begin
            a_r4_or_one_wins: assert (or_y[2*i +: 2] == 2'b11)
               else $error("R4: OR lane %0d not trusted 1", i);
         end

         if (xor_a[2*i] != xor_a[2*i+1] || xor_b[2*i] != xor_b[2*i+1]) begin
            a_r5_xor_untrusted: assert (xor_y[2*i +: 2] == 2'b01)
               else $error("R5: XOR lane %0d not untrusted", i);
         end

         if (inv_a[2*i +: 2] == 2'b10) begin
            a_r2_bad_code_untrusted: assert (inv_y[2*i +: 2] == 2'b01)
               else $error("R2: inverter lane %0d on code 10", i);
         end

         if (inv_a[2*i] == inv_a[2*i+1]) begin
            a_r6_inv_trusted: assert (inv_y[2*i] == inv_y[2*i+1] && inv_y[2*i] != inv_a[2*i])
               else $error("R6: inverter lane %0d trusted path", i);
         end

         if (vote_err[i]) begin
            a_r9_err_needs_trust: assert (mux_sel[2*i] == mux_sel[2*i+1] &&
                                          mux_d0[2*i] == mux_d0[2*i+1] &&
                                          mux_d1[2*i] == mux_d1[2*i+1])
               else $error("R9: flag with untrusted input on lane %0d", i);
         end
      end
   end
endmodule

bind trust_gate_lib trust_gate_lib_chk #(.LANES(LANES)) u_chk (
   .and_a (and_a), .and_b (and_b), .and_y (and_y),
   .or_a (or_a), .or_b (or_b), .or_y (or_y),
   .xor_a (xor_a), .xor_b (xor_b), .xor_y (xor_y),
   .inv_a (inv_a), .inv_y (inv_y),
   .mux_sel (mux_sel), .mux_d0 (mux_d0), .mux_d1 (mux_d1), .mux_y (mux_y),
   .vote_err (vote_err)
);

// File: tb/trust_gate_lib_test.sv
`timescale 1ns/1ps
module trust_gate_lib_test;
   localparam int L  = 4;
   localparam int CW = 2 * L;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [CW-1:0] and_a, and_b, and_y, or_a, or_b, or_y, xor_a, xor_b, xor_y;
   logic [CW-1:0] inv_a, inv_y, mux_sel, mux_d0, mux_d1, mux_y;
   logic [L-1:0]  plain_sel, plain_d0, plain_d1, vote_y, vote_err;

   trust_gate_lib #(.LANES(L)) uut (
      .and_a (and_a), .and_b (and_b), .and_y (and_y),
      .or_a (or_a), .or_b (or_b), .or_y (or_y),
      .xor_a (xor_a), .xor_b (xor_b), .xor_y (xor_y),
      .inv_a (inv_a), .inv_y (inv_y),
      .mux_sel (mux_sel), .mux_d0 (mux_d0), .mux_d1 (mux_d1), .mux_y (mux_y),
      .plain_sel (plain_sel), .plain_d0 (plain_d0), .plain_d1 (plain_d1),
      .vote_y (vote_y), .vote_err (vote_err)
   );

   typedef struct packed {
      logic [CW-1:0] e_and, e_or, e_xor, e_inv, e_mux;
      logic [L-1:0]  e_vote, e_err;
   } exp_t;

   exp_t q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // expected-value models taken from the requirement text
   function automatic logic [1:0] m_clean(logic [1:0] c);        // R2
      return (c == 2'b10) ? 2'b01 : c;
   endfunction
   function automatic logic [1:0] m_and(logic [1:0] a, logic [1:0] b); // R3
      logic [1:0] x = m_clean(a), y = m_clean(b);
      if (x == 2'b00 || y == 2'b00) return 2'b00;
      if (x == 2'b11 && y == 2'b11) return 2'b11;
      return 2'b01;
   endfunction
   function automatic logic [1:0] m_or(logic [1:0] a, logic [1:0] b);  // R4
      logic [1:0] x = m_clean(a), y = m_clean(b);
      if (x == 2'b11 || y == 2'b11) return 2'b11;
      if (x == 2'b00 && y == 2'b00) return 2'b00;
      return 2'b01;
   endfunction
   function automatic logic [1:0] m_xor(logic [1:0] a, logic [1:0] b); // R5
      logic [1:0] x = m_clean(a), y = m_clean(b);
      if (x == 2'b01 || y == 2'b01) return 2'b01;
      return (x == y) ? 2'b00 : 2'b11;
   endfunction
   function automatic logic [1:0] m_inv(logic [1:0] a);                // R6
      case (m_clean(a))
         2'b00:   return 2'b11;
         2'b11:   return 2'b00;
         default: return 2'b01;
      endcase
   endfunction
   function automatic logic [1:0] m_mux(logic [1:0] s, logic [1:0] d0, logic [1:0] d1); // R7
      case (m_clean(s))
         2'b00:   return m_clean(d0);
         2'b11:   return m_clean(d1);
         default: return (m_clean(d0) == 2'b00 && m_clean(d1) == 2'b00) ? 2'b00 : 2'b01;
      endcase
   endfunction

   task automatic check(string req, string what, int lane, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s lane %0d: actual %b expected %b", req, what, lane, act, exp);
      end
   endtask

   // driver: applies one vector and queues its expected results
   task automatic apply(int v, bit idle);
      logic [CW-1:0] aa, ab, oa, ob, xa, xb, ia, ms, m0, m1;
      logic [L-1:0]  ps, p0, p1;
      exp_t e;
      for (int k = 0; k < L; k++) begin
         logic [5:0] u;
         logic [1:0] cs, c0, c1, my;
         logic       pl, flip;
         u  = idle ? 6'd0 : 6'((v + 5 * k) & 63);
         cs = u[1:0]; c0 = u[3:2]; c1 = u[5:4];
         aa[2*k +: 2] = u[1:0]; ab[2*k +: 2] = u[3:2];
         oa[2*k +: 2] = u[3:2]; ob[2*k +: 2] = u[5:4];
         xa[2*k +: 2] = u[5:4]; xb[2*k +: 2] = u[1:0];
         ia[2*k +: 2] = u[3:2];
         ms[2*k +: 2] = cs; m0[2*k +: 2] = c0; m1[2*k +: 2] = c1;
         flip  = !idle && ((v % 7) == k);
         ps[k] = m_clean(cs)[1];
         p0[k] = m_clean(c0)[1] ^ flip;
         p1[k] = m_clean(c1)[1] ^ flip;
         e.e_and[2*k +: 2] = m_and(u[1:0], u[3:2]);
         e.e_or [2*k +: 2] = m_or (u[3:2], u[5:4]);
         e.e_xor[2*k +: 2] = m_xor(u[5:4], u[1:0]);
         e.e_inv[2*k +: 2] = m_inv(u[3:2]);
         my = m_mux(cs, c0, c1);
         e.e_mux[2*k +: 2] = my;
         pl = ps[k] ? p1[k] : p0[k];
         e.e_vote[k] = (pl & my[1]) | (pl & my[0]) | (my[1] & my[0]);   // R8
         e.e_err[k]  = (m_clean(cs) != 2'b01) && (m_clean(c0) != 2'b01) &&
                       (m_clean(c1) != 2'b01) && !(pl == my[1] && pl == my[0]); // R9
      end
      @(posedge clk);
      and_a = aa; and_b = ab; or_a = oa; or_b = ob; xor_a = xa; xor_b = xb;
      inv_a = ia; mux_sel = ms; mux_d0 = m0; mux_d1 = m1;
      plain_sel = ps; plain_d0 = p0; plain_d1 = p1;
      q.push_back(e);
   endtask

   // monitor: compares on the falling edge after the vector settles
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         for (int k = 0; k < L; k++) begin
            check("R3", "and", k, and_y[2*k +: 2], e.e_and[2*k +: 2]);
            check("R4", "or",  k, or_y[2*k +: 2],  e.e_or[2*k +: 2]);
            check("R5", "xor", k, xor_y[2*k +: 2], e.e_xor[2*k +: 2]);
            check("R6", "inv", k, inv_y[2*k +: 2], e.e_inv[2*k +: 2]);
            check("R7", "mux", k, mux_y[2*k +: 2], e.e_mux[2*k +: 2]);
            check("R1", "mux code", k, {1'b0, mux_y[2*k +: 2] == 2'b10}, 2'b00);
            check("R8", "vote", k, {1'b0, vote_y[k]},   {1'b0, e.e_vote[k]});
            check("R9", "err",  k, {1'b0, vote_err[k]}, {1'b0, e.e_err[k]});
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      and_a = '0; and_b = '0; or_a = '0; or_b = '0; xor_a = '0; xor_b = '0;
      inv_a = '0; mux_sel = '0; mux_d0 = '0; mux_d1 = '0;
      plain_sel = '0; plain_d0 = '0; plain_d1 = '0;
      apply(0, 1'b1);                 // idle state: all trusted zeros (R1)
      for (int v = 0; v < 64; v++)    // every code pair/triple on every lane (R2..R9)
         apply(v, 1'b0);
      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule